// File: doc/BRIEF.md
# Rectangle Fill and Colour-Expansion Engine

This block draws axis-aligned rectangles into a frame buffer reached through a 16-bit synchronous memory port with per-byte write enables. Three drawing operations are offered: a solid fill with the foreground colour, a tiled 8x8 colour pattern fetched from off-screen memory, and expansion of a monochrome bit stream from the host into 8 or 16 bpp colour, optionally transparent. Pixels are either 8 bits (two per memory word) or 16 bits (one per word).

Software places the operation parameters on the plain `cfg_*` inputs and pulses `start`. The engine captures every parameter in that cycle, raises `busy`, optionally loads the pattern into a local store, and then walks the rectangle line by line, writing one memory word per accepted request. After the final write is accepted it drops `busy` and pulses `done`. Monochrome data enters on a valid/ready port. A beat is taken only in a cycle where both `host_valid` and `host_ready` are high. The host must hold `host_valid` and `host_data` steady until the beat is taken, and the engine stalls its memory writes while it waits for data. Memory requests follow the same rule in the other direction: `mem_req` with its address, data, enables and direction stays unchanged until `mem_ready` is seen.

Top module: `rect_fill_engine`

## Requirements
- R1: Solid fill (`cfg_op`=0) stores the foreground colour into every pixel of the rectangle. At 16 bpp (`cfg_bpp16`=1) the whole 16-bit value is used. At 8 bpp only bits 7:0 are used.
- R2: At 8 bpp the pixel at byte address b lies in word b>>1, in bits 7:0 when b is even and in bits 15:8 when b is odd. Byte enables (`mem_be[0]` for bits 7:0, `mem_be[1]` for bits 15:8) leave every byte outside the rectangle unchanged, including the other half of the word at an odd first or last pixel.
- R3: Pattern fill (`cfg_op`=1) reads an 8x8 pattern from consecutive words starting at word `cfg_pat_base`. At 16 bpp pixel (row r, column c) is word base+8r+c. At 8 bpp it is byte 2*base+8r+c. The pixel at offset (x, y) from the rectangle origin receives pattern pixel (y mod 8, x mod 8).
- R4: Colour expansion (`cfg_op`=2) consumes host words most significant bit first, one bit per pixel. Every line starts on a fresh host word, and the unused bits of a line's last word are discarded. A 1 bit draws the foreground colour and a 0 bit draws the background colour, at 8 or 16 bpp.
- R5: With `cfg_transp`=1 during colour expansion, a 0 bit leaves that pixel's bytes unchanged. No write carries an all-zero byte enable.
- R6: `cfg_dst` is the byte address of the first pixel and must be even at 16 bpp. With `cfg_linear`=0, line y starts at `cfg_dst` + y*`cfg_pitch` bytes. With `cfg_linear`=1, lines are packed back to back at a stride of width times bytes per pixel.
- R7: `busy` is high from the cycle after an accepted `start` until the final write has been accepted. `done` is then high for exactly one cycle, and `busy` is already low in that cycle.
- R8: A `start` while `busy` is high is ignored. Parameter changes after the accepted `start` have no effect on the operation in progress. The engine makes no memory request while idle.
- R9: A zero width or zero height makes no memory access and still completes with `busy` for one cycle followed by a `done` pulse.
- R10: `host_ready` is high only during a colour-expansion operation when no host bits remain buffered. A memory request is held stable until `mem_ready`. Pattern reads return data on `mem_rdata` with `mem_rvalid` one cycle after acceptance.
- R11: After reset `busy`, `done`, `mem_req` and `host_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch strobe, taken when idle |
| cfg_op | input | 2 | 0 solid, 1 pattern, 2 colour expansion |
| cfg_bpp16 | input | 1 | 1: 16 bpp, 0: 8 bpp |
| cfg_linear | input | 1 | 1: packed lines, 0: pitch stride |
| cfg_transp | input | 1 | Transparent zero bits in expansion |
| cfg_dst | input | AW+1 | Destination byte address |
| cfg_width | input | CW | Width in pixels |
| cfg_height | input | CW | Height in lines |
| cfg_pitch | input | PW | Line stride in bytes |
| cfg_fg | input | 16 | Foreground colour |
| cfg_bg | input | 16 | Background colour |
| cfg_pat_base | input | AW | Pattern start word address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| host_valid | input | 1 | Host monochrome word valid |
| host_ready | output | 1 | Engine takes a host word |
| host_data | input | 16 | Monochrome bits, MSB first |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 write, 0 read |
| mem_ready | input | 1 | Memory accepts the request |
| mem_addr | output | AW | Word address |
| mem_be | output | 2 | Byte enables |
| mem_wdata | output | 16 | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |

## Verification
The two functions that can land on the same clock edge are the acceptance of a memory write and the end of a line. The same edge must retire the write, discard the remaining host bits, move the line start and, on the last line, raise `done`. The bench provokes this with random `mem_ready` gaps, random host-valid gaps and widths that are not a multiple of 16 or even odd, so line ends fall while the host buffer is part-full and while the memory is stalling. Every run is judged by a word-by-word comparison of the whole memory image, including the bytes around the rectangle, against a model that paints pixels from the requirements. The bench also checks that the number of host words taken matches the count the line rule predicts.

// File: rtl/rfe_pkg.sv
package rfe_pkg;
  localparam int RFE_DW  = 16;
  localparam int PAT_DIM = 8;

  typedef enum logic [1:0] {
    OP_SOLID   = 2'd0,
    OP_PATTERN = 2'd1,
    OP_EXPAND  = 2'd2
  } rfe_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREQ,
    ST_PWAIT,
    ST_FILL,
    ST_FIN
  } rfe_state_e;
endpackage

// File: rtl/rfe_pattern_buf.sv
module rfe_pattern_buf #(
  parameter int DW = 16,
  parameter int IW = 6
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic          wr_wide,
  input  logic [IW-1:0] wr_word,
  input  logic [DW-1:0] wr_data,
  input  logic [IW-1:0] rd_idx0,
  input  logic [IW-1:0] rd_idx1,
  output logic [DW-1:0] rd_pix0,
  output logic [DW-1:0] rd_pix1
);
  localparam int N  = 1 << IW;
  localparam int HB = DW / 2;

  logic [DW-1:0] store [N];

  // A wide word holds one pixel; a narrow word holds two byte pixels.
  always_ff @(posedge clk) begin
    if (wr_en) begin
      if (wr_wide) begin
        store[wr_word] <= wr_data;
      end else begin
        store[{wr_word[IW-2:0], 1'b0}] <= DW'(wr_data[HB-1:0]);
        store[{wr_word[IW-2:0], 1'b1}] <= DW'(wr_data[DW-1:HB]);
      end
    end
  end

  assign rd_pix0 = store[rd_idx0];
  assign rd_pix1 = store[rd_idx1];
endmodule

// File: rtl/rfe_mono_src.sv
module rfe_mono_src #(
  parameter int DW = 16,
  localparam int CNTW = $clog2(DW) + 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear,
  input  logic            want,
  input  logic            host_valid,
  input  logic [DW-1:0]   host_data,
  output logic            host_ready,
  input  logic            take_en,
  input  logic            take2,
  output logic            bit0,
  output logic            bit1,
  output logic [CNTW-1:0] avail
);
  logic [DW-1:0] sr;

  assign host_ready = want && (avail == '0);
  assign bit0 = sr[DW-1];
  assign bit1 = sr[DW-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr    <= '0;
      avail <= '0;
    end else if (clear) begin
      avail <= '0;
    end else if (host_valid && host_ready) begin
      sr    <= host_data;
      avail <= CNTW'(DW);
    end else if (take_en) begin
      if (take2) begin
        sr    <= {sr[DW-3:0], 2'b00};
        avail <= avail - CNTW'(2);
      end else begin
        sr    <= {sr[DW-2:0], 1'b0};
        avail <= avail - CNTW'(1);
      end
    end
  end
endmodule

// File: rtl/rfe_lane_pack.sv
module rfe_lane_pack #(
  parameter int DW = 16
) (
  input  logic          wide,
  input  logic          odd,
  input  logic          two,
  input  logic [DW-1:0] pix0,
  input  logic [DW-1:0] pix1,
  input  logic          wen0,
  input  logic          wen1,
  output logic [DW-1:0] wdata,
  output logic [1:0]    be
);
  localparam int HB = DW / 2;

  always_comb begin
    if (wide) begin
      wdata = pix0;
      be    = wen0 ? 2'b11 : 2'b00;
    end else if (odd) begin
      wdata = {pix0[HB-1:0], {HB{1'b0}}};
      be    = {wen0, 1'b0};
    end else begin
      wdata = {two ? pix1[HB-1:0] : {HB{1'b0}}, pix0[HB-1:0]};
      be    = {two && wen1, wen0};
    end
  end
endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine
  import rfe_pkg::*;
#(
  parameter int AW = 20,
  parameter int CW = 12,
  parameter int PW = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        cfg_op,
  input  logic              cfg_bpp16,
  input  logic              cfg_linear,
  input  logic              cfg_transp,
  input  logic [AW:0]       cfg_dst,
  input  logic [CW-1:0]     cfg_width,
  input  logic [CW-1:0]     cfg_height,
  input  logic [PW-1:0]     cfg_pitch,
  input  logic [RFE_DW-1:0] cfg_fg,
  input  logic [RFE_DW-1:0] cfg_bg,
  input  logic [AW-1:0]     cfg_pat_base,
  output logic              busy,
  output logic              done,
  input  logic              host_valid,
  output logic              host_ready,
  input  logic [RFE_DW-1:0] host_data,
  output logic              mem_req,
  output logic              mem_we,
  input  logic              mem_ready,
  output logic [AW-1:0]     mem_addr,
  output logic [1:0]        mem_be,
  output logic [RFE_DW-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [RFE_DW-1:0] mem_rdata
);
  localparam int BAW  = AW + 1;
  localparam int PB   = $clog2(PAT_DIM);
  localparam int PIDX = 2 * PB;
  localparam int CNTW = $clog2(RFE_DW) + 1;

  rfe_state_e        state;
  rfe_op_e           r_op;
  logic              r_bpp16, r_transp;
  logic [BAW-1:0]    r_stride, lb;
  logic [CW-1:0]     r_width, r_height, x, y;
  logic [RFE_DW-1:0] r_fg, r_bg;
  logic [AW-1:0]     r_pbase;
  logic [PIDX-1:0]   pk;

  logic [BAW-1:0]    xoff, ba;
  logic [CW-1:0]     rem;
  logic [CW:0]       x_next;
  logic              is_exp, have_bits, two, line_end, last_line, in_fill, step, start_ok;
  logic              bit0, bit1, wen0, wen1;
  logic [CNTW-1:0]   avail;
  logic [RFE_DW-1:0] pat0, pat1, pix0, pix1, wdata;
  logic [1:0]        be;
  logic [PIDX-1:0]   pk_last;

  assign in_fill  = (state == ST_FILL);
  assign start_ok = start && (state == ST_IDLE);
  assign busy     = (state != ST_IDLE);
  assign is_exp   = (r_op == OP_EXPAND);

  // Destination position of the word being written.
  assign xoff      = r_bpp16 ? BAW'({x, 1'b0}) : BAW'(x);
  assign ba        = lb + xoff;
  assign rem       = r_width - x;
  assign have_bits = !is_exp || (avail != '0);
  assign two       = !r_bpp16 && !ba[0] && (rem >= CW'(2)) && (!is_exp || avail >= CNTW'(2));
  assign x_next    = {1'b0, x} + (two ? (CW+1)'(2) : (CW+1)'(1));
  assign line_end  = (x_next == {1'b0, r_width});
  assign last_line = (y == r_height - CW'(1));
  assign pk_last   = r_bpp16 ? {PIDX{1'b1}} : {1'b0, {(PIDX-1){1'b1}}};

  rfe_pattern_buf #(.DW(RFE_DW), .IW(PIDX)) u_pat (
    .clk     (clk),
    .wr_en   (state == ST_PWAIT && mem_rvalid),
    .wr_wide (r_bpp16),
    .wr_word (pk),
    .wr_data (mem_rdata),
    .rd_idx0 ({y[PB-1:0], x[PB-1:0]}),
    .rd_idx1 ({y[PB-1:0], x[PB-1:0] + PB'(1)}),
    .rd_pix0 (pat0),
    .rd_pix1 (pat1)
  );

  rfe_mono_src #(.DW(RFE_DW)) u_mono (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear      (start_ok || (step && line_end)),
    .want       (in_fill && is_exp),
    .host_valid (host_valid),
    .host_data  (host_data),
    .host_ready (host_ready),
    .take_en    (step && is_exp),
    .take2      (two),
    .bit0       (bit0),
    .bit1       (bit1),
    .avail      (avail)
  );

  always_comb begin
    unique case (r_op)
      OP_PATTERN: begin pix0 = pat0; pix1 = pat1; end
      OP_EXPAND:  begin pix0 = bit0 ? r_fg : r_bg; pix1 = bit1 ? r_fg : r_bg; end
      default:    begin pix0 = r_fg; pix1 = r_fg; end
    endcase
  end
  assign wen0 = !(is_exp && r_transp && !bit0);
  assign wen1 = !(is_exp && r_transp && !bit1);

  rfe_lane_pack #(.DW(RFE_DW)) u_pack (
    .wide  (r_bpp16),
    .odd   (ba[0]),
    .two   (two),
    .pix0  (pix0),
    .pix1  (pix1),
    .wen0  (wen0),
    .wen1  (wen1),
    .wdata (wdata),
    .be    (be)
  );

  assign step      = in_fill && have_bits && (be == 2'b00 || mem_ready);
  assign mem_req   = (in_fill && have_bits && be != 2'b00) || (state == ST_PREQ);
  assign mem_we    = in_fill;
  assign mem_addr  = in_fill ? ba[BAW-1:1] : r_pbase + AW'(pk);
  assign mem_be    = in_fill ? be : 2'b11;
  assign mem_wdata = in_fill ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;  done <= 1'b0;  r_op <= OP_SOLID;
      r_bpp16 <= 1'b0;   r_transp <= 1'b0;
      r_stride <= '0;    lb <= '0;  r_width <= '0;  r_height <= '0;
      x <= '0;  y <= '0; r_fg <= '0; r_bg <= '0; r_pbase <= '0; pk <= '0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (start) begin
          r_op     <= rfe_op_e'(cfg_op);
          r_bpp16  <= cfg_bpp16;
          r_transp <= cfg_transp;
          r_width  <= cfg_width;
          r_height <= cfg_height;
          r_fg     <= cfg_fg;
          r_bg     <= cfg_bg;
          r_pbase  <= cfg_pat_base;
          r_stride <= cfg_linear ? (cfg_bpp16 ? BAW'({cfg_width, 1'b0}) : BAW'(cfg_width))
                                 : BAW'(cfg_pitch);
          lb <= cfg_dst;  x <= '0;  y <= '0;  pk <= '0;
          if (cfg_width == '0 || cfg_height == '0) state <= ST_FIN;
          else if (rfe_op_e'(cfg_op) == OP_PATTERN) state <= ST_PREQ;
          else state <= ST_FILL;
        end
        ST_PREQ:  if (mem_ready) state <= ST_PWAIT;
        ST_PWAIT: if (mem_rvalid) begin
          pk    <= pk + PIDX'(1);
          state <= (pk == pk_last) ? ST_FILL : ST_PREQ;
        end
        ST_FILL: if (step) begin
          if (line_end) begin
            x  <= '0;
            y  <= y + CW'(1);
            lb <= lb + r_stride;
            if (last_line) begin
              state <= ST_IDLE;
              done  <= 1'b1;
            end
          end else begin
            x <= x_next[CW-1:0];
          end
        end
        ST_FIN: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rfe_checker.sv
module rfe_checker #(
  parameter int AW = 20
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          host_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ready,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    mem_be,
  input logic [15:0]   mem_wdata
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_be) && $stable(mem_wdata)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R7
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy |=> busy); // R7
  AST_HOST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    host_ready |-> busy && !mem_req); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req); // R8
  AST_BE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> mem_be != 2'b00); // R5
endmodule

bind rect_fill_engine rfe_checker #(.AW(AW)) u_rfe_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .busy       (busy),
  .done       (done),
  .host_ready (host_ready),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_ready  (mem_ready),
  .mem_addr   (mem_addr),
  .mem_be     (mem_be),
  .mem_wdata  (mem_wdata)
);

// File: tb/rect_fill_engine_tb_top.sv
module rect_fill_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12, CW = 12, PW = 14;
  localparam int MEMW = 4096;
  localparam int WAIT_LIMIT = 20000;
  localparam int PBASE = 3000;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic rst_n = 1'b0, start = 1'b0;
  logic [1:0] cfg_op = '0;
  logic cfg_bpp16 = 1'b0, cfg_linear = 1'b0, cfg_transp = 1'b0;
  logic [AW:0] cfg_dst = '0;
  logic [CW-1:0] cfg_width = '0, cfg_height = '0;
  logic [PW-1:0] cfg_pitch = '0;
  logic [15:0] cfg_fg = '0, cfg_bg = '0;
  logic [AW-1:0] cfg_pat_base = '0;
  logic busy, done, host_ready, mem_req, mem_we;
  logic host_valid = 1'b0;
  logic [15:0] host_data = '0;
  logic mem_ready = 1'b0, mem_rvalid = 1'b0;
  logic [AW-1:0] mem_addr;
  logic [1:0] mem_be;
  logic [15:0] mem_wdata, mem_rdata = '0;

  rect_fill_engine #(.AW(AW), .CW(CW), .PW(PW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_op(cfg_op), .cfg_bpp16(cfg_bpp16),
    .cfg_linear(cfg_linear), .cfg_transp(cfg_transp), .cfg_dst(cfg_dst),
    .cfg_width(cfg_width), .cfg_height(cfg_height), .cfg_pitch(cfg_pitch),
    .cfg_fg(cfg_fg), .cfg_bg(cfg_bg), .cfg_pat_base(cfg_pat_base), .busy(busy),
    .done(done), .host_valid(host_valid), .host_ready(host_ready), .host_data(host_data),
    .mem_req(mem_req), .mem_we(mem_we), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  logic [15:0] mem [MEMW];
  logic [15:0] base_img [MEMW];
  logic [15:0] refm [MEMW];
  logic [15:0] hw [256];
  logic load_img = 1'b0, hclr = 1'b0, taken = 1'b0;
  int hcount = 0, hidx = 0;
  int checks = 0, fails = 0;

  // Memory model: one-cycle read latency, byte-enabled writes.
  always @(posedge clk) begin
    if (load_img) begin
      for (int i = 0; i < MEMW; i++) mem[i] <= base_img[i];
    end else if (mem_req && mem_ready && mem_we) begin
      if (mem_be[0]) mem[mem_addr][7:0]  <= mem_wdata[7:0];
      if (mem_be[1]) mem[mem_addr][15:8] <= mem_wdata[15:8];
    end
    mem_rvalid <= mem_req && mem_ready && !mem_we;
    mem_rdata  <= mem[mem_addr];
  end
  always @(negedge clk) mem_ready <= ($urandom % 4) != 0;

  // Host source: holds a beat until taken, random gaps between beats.
  always @(posedge clk) begin
    if (hclr) begin
      hidx <= 0; taken <= 1'b0;
    end else begin
      taken <= host_valid && host_ready;
      if (host_valid && host_ready) hidx <= hidx + 1;
    end
  end
  always @(negedge clk) begin
    if (hclr) host_valid <= 1'b0;
    else if (!host_valid || taken) begin
      host_valid <= (hidx < hcount) && (($urandom % 3) != 0);
      host_data  <= hw[hidx[7:0]];
    end
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic put_byte(int b, logic [7:0] v);
    if (b % 2 == 1) refm[b/2][15:8] = v; else refm[b/2][7:0] = v;
  endtask
  function automatic logic [7:0] get_byte(int b);
    return (b % 2 == 1) ? refm[b/2][15:8] : refm[b/2][7:0];
  endfunction

  // Paints the expected image from the requirements.
  task automatic build_ref();
    int bpb = cfg_bpp16 ? 2 : 1;
    int w = int'(cfg_width), h = int'(cfg_height);
    int stride = cfg_linear ? w * bpb : int'(cfg_pitch);
    int wpl = (w + 15) / 16;
    for (int yy = 0; yy < h; yy++) begin
      for (int xx = 0; xx < w; xx++) begin
        int ba = int'(cfg_dst) + yy * stride + xx * bpb;
        logic [15:0] pv;
        bit skip = 1'b0;
        if (cfg_op == 2'd1) begin
          if (cfg_bpp16) pv = refm[PBASE + 8 * (yy % 8) + (xx % 8)];
          else pv = {8'h00, get_byte(2 * PBASE + 8 * (yy % 8) + (xx % 8))};
        end else if (cfg_op == 2'd2) begin
          bit b = hw[yy * wpl + xx / 16][15 - (xx % 16)];
          if (cfg_transp && !b) skip = 1'b1;
          pv = b ? cfg_fg : cfg_bg;
        end else begin
          pv = cfg_fg;
        end
        if (!skip) begin
          put_byte(ba, pv[7:0]);
          if (cfg_bpp16) put_byte(ba + 1, pv[15:8]);
        end
      end
    end
  endtask

  task automatic prep(int op, bit b16, bit lin, bit tr, int dst, int w, int h, int extra);
    cfg_op = 2'(op); cfg_bpp16 = b16; cfg_linear = lin; cfg_transp = tr;
    cfg_dst = (AW+1)'(b16 ? (dst & ~1) : dst);
    cfg_width = CW'(w); cfg_height = CW'(h);
    cfg_pitch = PW'(w * (b16 ? 2 : 1) + (b16 ? (extra & ~1) : extra));
    cfg_fg = 16'($urandom); cfg_bg = 16'($urandom);
    cfg_pat_base = AW'(PBASE);
    for (int i = 0; i < 256; i++) hw[i] = 16'($urandom);
  endtask

  task automatic run_op(string tag, bit inject);
    int n = 0, wpl, exp_h, bad_at = -1;
    bit bad_busy = 1'b0, bad_hr = 1'b0;
    bit is_exp = (cfg_op == 2'd2);
    wpl = (int'(cfg_width) + 15) / 16;
    exp_h = is_exp ? wpl * int'(cfg_height) : 0;
    for (int i = 0; i < MEMW; i++) begin
      base_img[i] = 16'($urandom);
      refm[i] = base_img[i];
    end
    build_ref();
    hcount = 0; hclr = 1'b1; load_img = 1'b1;
    @(negedge clk); @(negedge clk);
    hclr = 1'b0; load_img = 1'b0; hcount = exp_h;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(busy === 1'b1, "R7", "busy after start", busy, 1);
    while (done !== 1'b1 && n < WAIT_LIMIT) begin
      @(negedge clk);
      n++;
      if (inject && n == 2) begin
        start = 1'b1; cfg_fg = ~cfg_fg; cfg_dst = cfg_dst + 2;
      end
      if (inject && n == 3) start = 1'b0;
      if (done !== 1'b1 && busy !== 1'b1) bad_busy = 1'b1;
      if (!is_exp && host_ready === 1'b1) bad_hr = 1'b1;
    end
    check(n < WAIT_LIMIT, "R7", "watchdog cycles", n, WAIT_LIMIT);
    check(!bad_busy, "R7", "busy held until done", bad_busy, 0);
    check(!bad_hr, "R10", "host_ready outside expansion", bad_hr, 0);
    check(busy === 1'b0, "R7", "busy low with done", busy, 0);
    @(negedge clk);
    check(done === 1'b0, "R7", "done single cycle", done, 0);
    for (int i = 0; i < MEMW; i++)
      if (bad_at < 0 && mem[i] !== refm[i]) bad_at = i;
    if (bad_at >= 0)
      check(1'b0, tag, $sformatf("image word %0d", bad_at), mem[bad_at], refm[bad_at]);
    else
      check(1'b1, tag, "image", 0, 0);
    if (is_exp) check(hidx == exp_h, "R4", "host words taken", hidx, exp_h);
    if (inject) begin
      bit relaunched = 1'b0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (busy !== 1'b0 || mem_req !== 1'b0) relaunched = 1'b1;
      end
      check(!relaunched, "R8", "no second launch", relaunched, 0);
    end
  endtask

  initial begin
    void'($urandom(32'd7311));
    repeat (3) @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R11", "busy/done at reset", {busy, done}, 0);
    check(mem_req === 1'b0 && host_ready === 1'b0, "R11", "req/ready at reset",
          {mem_req, host_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    prep(0, 1, 0, 0, 500, 13, 5, 6);   run_op("R1", 0);
    prep(0, 0, 0, 0, 501, 9, 4, 3);    run_op("R2", 0);   // odd start, odd end
    prep(0, 0, 0, 0, 600, 1, 3, 5);    run_op("R2", 0);   // single even pixel
    prep(1, 0, 0, 0, 403, 19, 10, 2);  run_op("R3", 0);
    prep(1, 1, 1, 0, 700, 11, 9, 0);   run_op("R6", 0);   // packed lines
    prep(2, 0, 0, 1, 451, 21, 4, 7);   run_op("R5", 0);
    prep(2, 1, 0, 0, 300, 17, 3, 4);   run_op("R4", 0);
    prep(2, 0, 1, 0, 911, 33, 2, 0);   run_op("R6", 0);
    prep(0, 1, 0, 0, 420, 0, 5, 4);    run_op("R9", 0);   // zero width
    prep(1, 1, 0, 0, 420, 6, 0, 4);    run_op("R9", 0);   // zero height
    prep(0, 1, 0, 0, 200, 30, 8, 10);  run_op("R8", 1);   // start while busy

    for (int t = 0; t < 30; t++) begin
      int op = int'($urandom % 3);
      bit b16 = 1'($urandom);
      bit lin = ($urandom % 4) == 0;
      bit tr = (op == 2) && 1'($urandom);
      prep(op, b16, lin, tr, 400 + int'($urandom % 200), 1 + int'($urandom % 40),
           1 + int'($urandom % 12), int'($urandom % 20));
      run_op(op == 0 ? "R1" : op == 1 ? "R3" : tr ? "R5" : "R4", 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule